// File: doc/BRIEF.md
# Supply voltage detector controller

This block is the digital side of an on-chip supply voltage detector. It sits on a 4-bit register bus (address, write strobe, write data, combinational read data) and holds two nibble registers at adjacent addresses. The lower one selects the detection threshold. The upper one turns the detector on and off and returns the detection result. The threshold code and the enable line are driven straight to an external analog comparator. The comparator's "supply below threshold" output comes back as a digital input and passes through a two-flop synchroniser.

The result is taken only when software switches the detector off. On that 1-to-0 change of the enable bit, the synchronised comparator level is loaded into a read-only latch. While the detector is on, a counter measures the settle time. It reports through a separate status output whether the detector had been on long enough for the latched result to be trusted. The required on-time in clock cycles is derived from the clock frequency and the settle time in microseconds.

Top module: `vdet_ctrl`

## Requirements
- R1: After reset the threshold register, the enable bit, the result latch, `result_valid_o`, `det_en_o` and `det_sel_o` are all 0.
- R2: The threshold register sits at address `BASE_ADDR`. All four bits can be written and read back, and `det_sel_o` carries the new value from the write edge on. The code is passed unchanged: code 0 selects the external ~1.05 V reference, and codes 10 to 15 select 2.80 V to 3.30 V in 0.1 V steps.
- R3: At address `BASE_ADDR+1`, bit 0 is the enable bit. It can be read and written, and `det_en_o` follows it from the write edge.
- R4: Bit 1 at `BASE_ADDR+1` is the result latch: 1 means the supply is below the threshold, 0 means it is at or above it. The latch loads the synchronised comparator level only at the clock edge where the enable bit goes from 1 to 0, and it holds that value until the next such edge.
- R5: Writes to bit 1 at `BASE_ADDR+1` have no effect. Bits 3 and 2 at that address always read 0.
- R6: Writing 0 while the detector is off captures nothing. Writing 1 while it is on neither restarts the settle count nor changes the latch.
- R7: `result_valid_o` is updated at the same edge as the latch. It becomes 1 only if the enable bit had been 1 for at least SETTLE_CYC = (CLK_HZ/1e6)·SETTLE_US clock cycles before the clearing edge, and 0 otherwise.
- R8: A level on `below_i` that has been present for two rising edges before the clearing edge is captured. A change first presented at the clearing edge itself is not captured; the old level is latched instead.
- R9: Reads of any other address return 0, and writes to any other address change no register.
- R10: `rdata_o` is combinational from `addr_i` and the current register state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Register address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 4 | Write data |
| rdata_o | output | 4 | Read data for addr_i |
| below_i | input | 1 | Comparator output, 1 = supply below threshold (asynchronous) |
| det_en_o | output | 1 | Detector enable to the analog side |
| det_sel_o | output | 4 | Threshold code to the analog side |
| result_valid_o | output | 1 | Last capture happened after the settle time had elapsed |

## Verification
A settle counter that restarts, drifts or fails to clear shows up only at the next clearing edge, as a wrong `result_valid_o`. For that reason the bench clears the enable one cycle either side of the SETTLE_CYC boundary, and again after rewriting 1 in the middle of an on-period. A wrong latch enable shows up immediately as a changed bit 1 on the next read, after idle writes of 0 or 1 and while `below_i` moves with the detector off. A synchroniser depth that is wrong by one stage flips the captured level when `below_i` changes right at the clearing edge, or two edges before it.

// File: rtl/vdet_pkg.sv
package vdet_pkg;
  typedef logic [3:0] nib_t;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_THR  = 2'd1,
    SEL_CTRL = 2'd2
  } reg_sel_e;

  function automatic int settle_cycles(int clk_hz, int settle_us);
    return (clk_hz / 1_000_000) * settle_us;
  endfunction
endpackage

// File: rtl/vdet_sync.sv
module vdet_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q <= '0;
        else         stage_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q <= '0;
        else         stage_q <= {stage_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/vdet_regs.sv
module vdet_regs
  import vdet_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int unsigned BASE_ADDR = 'hFF04
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  nib_t              wdata_i,
  input  logic              result_i,
  output nib_t              rdata_o,
  output nib_t              thr_o,
  output logic              en_q_o,
  output logic              en_d_o
);
  localparam logic [ADDR_W-1:0] ThrAddr  = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] CtrlAddr = ADDR_W'(BASE_ADDR + 1);

  reg_sel_e sel;
  nib_t     thr_q;
  logic     en_q;

  always_comb begin
    if (addr_i == ThrAddr)       sel = SEL_THR;
    else if (addr_i == CtrlAddr) sel = SEL_CTRL;
    else                         sel = SEL_NONE;
  end

  // next enable value, shared with the capture edge detector
  assign en_d_o = (we_i && sel == SEL_CTRL) ? wdata_i[0] : en_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                     thr_q <= '0;
    else if (we_i && sel == SEL_THR) thr_q <= wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_d_o;

  always_comb begin
    unique case (sel)
      SEL_THR:  rdata_o = thr_q;
      SEL_CTRL: rdata_o = {2'b00, result_i, en_q};
      default:  rdata_o = '0;
    endcase
  end

  assign thr_o  = thr_q;
  assign en_q_o = en_q;

  assert_thr_wr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ThrAddr) |=> thr_q == $past(wdata_i));
  assert_en_wr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == CtrlAddr) |=> en_q == $past(wdata_i[0]));
  assert_foreign_wr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i != ThrAddr && addr_i != CtrlAddr) |=> ($stable(thr_q) && $stable(en_q)));
endmodule

// File: rtl/vdet_settle.sv
module vdet_settle #(
  parameter int CYC = 20000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic settled_o
);
  localparam int            CW   = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [CW-1:0] Last = CW'(CYC - 1);

  logic [CW-1:0] cnt_q;

  // counts enabled cycles after the first, saturates at Last
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)            cnt_q <= '0;
    else if (!en_i)         cnt_q <= '0;
    else if (cnt_q != Last) cnt_q <= cnt_q + 1'b1;

  assign settled_o = (cnt_q == Last);

  assert_idle_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0);
  assert_sat_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && settled_o) |=> settled_o);
  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= Last);
endmodule

// File: rtl/vdet_capture.sv
module vdet_capture (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_q_i,
  input  logic en_d_i,
  input  logic below_s_i,
  input  logic settled_i,
  output logic result_o,
  output logic valid_o
);
  logic fall;
  logic result_q, valid_q;

  assign fall = en_q_i & ~en_d_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      result_q <= 1'b0;
      valid_q  <= 1'b0;
    end else if (fall) begin
      result_q <= below_s_i;
      valid_q  <= settled_i;
    end

  assign result_o = result_q;
  assign valid_o  = valid_q;

  assert_cap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q_i && !en_d_i) |=> result_q == $past(below_s_i));
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_q_i && !en_d_i) |=> ($stable(result_q) && $stable(valid_q)));
  assert_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q_i && !en_d_i) |=> valid_q == $past(settled_i));
endmodule

// File: rtl/vdet_ctrl.sv
module vdet_ctrl
  import vdet_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int unsigned BASE_ADDR   = 'hFF04,
  parameter int          CLK_HZ      = 200_000_000,
  parameter int          SETTLE_US   = 100,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [3:0]        wdata_i,
  output logic [3:0]        rdata_o,
  input  logic              below_i,
  output logic              det_en_o,
  output logic [3:0]        det_sel_o,
  output logic              result_valid_o
);
  localparam int SettleCyc = settle_cycles(CLK_HZ, SETTLE_US);
  localparam logic [ADDR_W-1:0] CtrlAddr = ADDR_W'(BASE_ADDR + 1);
  localparam logic [ADDR_W-1:0] ThrAddr  = ADDR_W'(BASE_ADDR);

  nib_t thr;
  logic en_q, en_d, below_s, settled, result;

  vdet_regs #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_regs (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i,
    .result_i(result), .rdata_o, .thr_o(thr), .en_q_o(en_q), .en_d_o(en_d)
  );

  vdet_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(below_i), .q_o(below_s)
  );

  vdet_settle #(.CYC(SettleCyc)) u_settle (
    .clk_i, .rst_ni, .en_i(en_q), .settled_o(settled)
  );

  vdet_capture u_cap (
    .clk_i, .rst_ni, .en_q_i(en_q), .en_d_i(en_d), .below_s_i(below_s),
    .settled_i(settled), .result_o(result), .valid_o(result_valid_o)
  );

  assign det_en_o  = en_q;
  assign det_sel_o = thr;

  assert_hi_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == CtrlAddr) |-> rdata_o[3:2] == 2'b00);
  assert_sel_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == ThrAddr) |=> $stable(det_sel_o));
endmodule

// File: tb/vdet_ctrl_tb.sv
module vdet_ctrl_tb;
  localparam int ADDR_W = 16;
  localparam int unsigned BASE = 'hFF04;
  localparam int SETTLE = 20;  // 1 MHz x 20 us
  localparam logic [15:0] A_THR = 16'hFF04, A_CTRL = 16'hFF05;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic we = 1'b0, below = 1'b0;
  logic [3:0] wdata = '0, rdata, sel;
  logic en, valid;
  int n_run = 0, n_fail = 0, cycles = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  vdet_ctrl #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE), .CLK_HZ(1_000_000), .SETTLE_US(SETTLE)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .below_i(below), .det_en_o(en), .det_sel_o(sel),
    .result_valid_o(valid)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [3:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output logic [3:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  // on, hold for m enabled cycles in total, then off
  task automatic run_detect(int m);
    wr(A_CTRL, 4'h1);
    repeat (m - 2) @(negedge clk);
    wr(A_CTRL, 4'h0);
  endtask

  task automatic t_reset();
    logic [3:0] d;
    rd(A_THR, d);  chk("R1", "thr", d, 0);
    rd(A_CTRL, d); chk("R1", "ctrl", d, 0);
    chk("R1", "det_en", en, 0);
    chk("R1", "det_sel", sel, 0);
    chk("R1", "valid", valid, 0);
  endtask

  task automatic t_thr();
    logic [3:0] d;
    int codes[4] = '{0, 10, 15, 5};
    foreach (codes[i]) begin
      wr(A_THR, 4'(codes[i]));
      chk("R2", "det_sel", sel, codes[i]);
      rd(A_THR, d); chk("R10", "thr readback", d, codes[i]);
    end
  endtask

  task automatic t_enable();
    logic [3:0] d;
    below = 1'b0;
    wr(A_CTRL, 4'h1);
    chk("R3", "det_en on", en, 1);
    wr(A_CTRL, 4'hF);
    rd(A_CTRL, d); chk("R5", "upper bits zero", d, 1);
    wr(A_CTRL, 4'h0);
    chk("R3", "det_en off", en, 0);
    rd(A_CTRL, d); chk("R4", "result at/above", d, 0);
  endtask

  task automatic t_capture();
    logic [3:0] d;
    below = 1'b1;
    repeat (3) @(negedge clk);
    run_detect(SETTLE);
    rd(A_CTRL, d); chk("R4", "result below", d, 2);
    chk("R7", "valid at boundary", valid, 1);
    below = 1'b0;
    repeat (5) @(negedge clk);
    rd(A_CTRL, d); chk("R4", "latch holds", d, 2);
  endtask

  task automatic t_ignore();
    logic [3:0] d;
    wr(A_CTRL, 4'h0);
    rd(A_CTRL, d); chk("R6", "idle off write no capture", d, 2);
    chk("R6", "valid held", valid, 1);
    below = 1'b0;
    run_detect(SETTLE);
    wr(A_CTRL, 4'h2);
    rd(A_CTRL, d); chk("R5", "bit1 write ignored", d, 0);
  endtask

  task automatic t_settle();
    below = 1'b1;
    repeat (3) @(negedge clk);
    run_detect(SETTLE - 1);
    chk("R7", "valid short", valid, 0);
    run_detect(SETTLE);
    chk("R7", "valid exact", valid, 1);
  endtask

  task automatic t_rewrite();
    logic [3:0] d;
    // latch now holds 1; supply goes above
    below = 1'b0;
    repeat (3) @(negedge clk);
    wr(A_CTRL, 4'h1);
    repeat (5) @(negedge clk);
    wr(A_CTRL, 4'h1);
    rd(A_CTRL, d); chk("R6", "rewrite keeps latch", d, 3);
    repeat (SETTLE - 10) @(negedge clk);
    wr(A_CTRL, 4'h0);
    chk("R6", "rewrite no restart", valid, 1);
    rd(A_CTRL, d); chk("R4", "result above", d, 0);
  endtask

  task automatic t_sync();
    logic [3:0] d;
    below = 1'b1;
    repeat (3) @(negedge clk);
    wr(A_CTRL, 4'h1);
    repeat (SETTLE) @(negedge clk);
    @(negedge clk); below = 1'b0; addr = A_CTRL; wdata = 4'h0; we = 1'b1;
    @(negedge clk); we = 1'b0;
    rd(A_CTRL, d); chk("R8", "late change not captured", d, 2);
    wr(A_CTRL, 4'h1);
    repeat (SETTLE) @(negedge clk);
    @(negedge clk); below = 1'b1;
    @(negedge clk);
    wr(A_CTRL, 4'h0);
    rd(A_CTRL, d); chk("R8", "two-edge change captured", d, 2);
    below = 1'b0;
    repeat (3) @(negedge clk);
    wr(A_CTRL, 4'h1);
    repeat (SETTLE) @(negedge clk);
    @(negedge clk); below = 1'b1;
    @(negedge clk);
    wr(A_CTRL, 4'h0);
    rd(A_CTRL, d); chk("R8", "two-edge rise captured", d, 2);
  endtask

  task automatic t_addr();
    logic [3:0] d;
    wr(A_THR, 4'h7);
    wr(16'hFF06, 4'hF);
    wr(16'hFF03, 4'hF);
    rd(16'hFF06, d); chk("R9", "foreign read", d, 0);
    rd(16'hFF03, d); chk("R9", "foreign read low", d, 0);
    rd(A_THR, d); chk("R9", "thr untouched", d, 7);
    chk("R9", "det_en untouched", en, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100_000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_thr();
    t_enable();
    t_capture();
    t_ignore();
    t_settle();
    t_rewrite();
    t_sync();
    t_addr();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule